// File: doc/BRIEF.md
# HDLC Byte FIFO Pair

This block holds the two byte buffers that sit between a host bus and an HDLC framer. The host fills the transmit buffer, and the HDLC transmit engine drains it. The HDLC receive engine fills the receive buffer, and the host drains it. Both buffers share one clock and one synchronous reset. Each buffer is 256 bytes deep by default.

Some accesses are illegal: a host write into a full transmit buffer, an engine read from an empty transmit buffer, or a host read from an empty receive buffer. The block ignores such an access and leaves the buffer contents and pointers unchanged. It reports the access on a dedicated flag, which a separate status block can latch. The transmit side also shows at all times how many bytes the host may still write. The receive side raises a level flag once enough bytes have arrived to justify a host burst read.

Top module: `hdlc_byte_fifo_pair`

## Requirements
- R1: A transmit write (`tx_wr_en`) while `tx_free` is 0 leaves the stored bytes unchanged. `tx_ovf` is 1 on the cycle after that clock edge.
- R2: A transmit read (`tx_rd_en`) while `tx_free` equals DEPTH moves no pointer. On the cycle after that edge, `tx_unf` is 1 and `tx_rd_valid` is 0.
- R3: A receive read (`rx_rd_en`) while the receive buffer is empty moves no pointer. On the cycle after that edge, `rx_rd_invalid` is 1 and `rx_rd_valid` is 0.
- R4: `tx_free` is 9 bits wide and equals DEPTH minus the number of bytes stored in the transmit buffer. It updates on the cycle after each accepted write or read.
- R5: `rx_level` is 1 exactly while the receive buffer holds LEVEL (16) or more bytes.
- R6: Each buffer holds DEPTH (256) bytes and returns them in write order. Read data appears on `*_rd_data` with `*_rd_valid` = 1 on the cycle after an accepted read.
- R7: `tx_ovf`, `tx_unf` and `rx_rd_invalid` last one cycle for each offending access. They return to 0 on the next cycle if no new offending access occurs.
- R8: When a write and a read hit the same buffer in the same cycle, a write while full is dropped even though a read is accepted, and a read while empty is rejected even though a write is accepted.
- R9: A synchronous `rst` empties both buffers, sets `tx_free` to 256, and clears every flag and valid output.
- R10: A receive write while the receive buffer is full is dropped and leaves the stored bytes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_wr_en | input | 1 | Host write strobe, transmit buffer |
| tx_wr_data | input | 8 | Host write byte |
| tx_rd_en | input | 1 | Transmit engine read strobe |
| tx_rd_data | output | 8 | Byte to the transmit engine |
| tx_rd_valid | output | 1 | `tx_rd_data` holds an accepted byte |
| tx_free | output | 9 | Bytes the host may still write |
| tx_ovf | output | 1 | Overflow event pulse |
| tx_unf | output | 1 | Underflow event pulse |
| rx_wr_en | input | 1 | Receive engine write strobe |
| rx_wr_data | input | 8 | Received byte |
| rx_rd_en | input | 1 | Host read strobe, receive buffer |
| rx_rd_data | output | 8 | Byte to the host |
| rx_rd_valid | output | 1 | `rx_rd_data` holds an accepted byte |
| rx_rd_invalid | output | 1 | Pulse: last host read found the buffer empty |
| rx_level | output | 1 | LEVEL or more bytes stored |

## Verification
The risky overlap is a write and a read on the same buffer in one cycle while that buffer is at a boundary.

The bench provokes this overlap in two ways:
- It fills the transmit buffer completely, then applies a host write and an engine read together. It expects an overflow pulse, a valid read byte and a free count of 1.
- It leaves the receive buffer empty, then applies a receive write and a host read together. It expects an invalid pulse, and expects the written byte to come out on the following read.

Both outcomes are also judged by bound properties that tie the boundary state to the next cycle's flags.

// File: rtl/hdlc_byte_fifo_pair.sv
module hdlc_byte_fifo_pair #(
  parameter int DEPTH = 256,
  parameter int LEVEL = 16,
  parameter int DW    = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tx_wr_en,
  input  logic [DW-1:0]      tx_wr_data,
  input  logic               tx_rd_en,
  output logic [DW-1:0]      tx_rd_data,
  output logic               tx_rd_valid,
  output logic [$clog2(DEPTH+1)-1:0] tx_free,
  output logic               tx_ovf,
  output logic               tx_unf,
  input  logic               rx_wr_en,
  input  logic [DW-1:0]      rx_wr_data,
  input  logic               rx_rd_en,
  output logic [DW-1:0]      rx_rd_data,
  output logic               rx_rd_valid,
  output logic               rx_rd_invalid,
  output logic               rx_level
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH-1);

  logic [DW-1:0] tx_mem [DEPTH];
  logic [DW-1:0] rx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;

  wire tx_full  = (tx_cnt == FULL);
  wire tx_empty = (tx_cnt == '0);
  wire rx_full  = (rx_cnt == FULL);
  wire rx_empty = (rx_cnt == '0);

  wire tx_wr_ok = tx_wr_en && !tx_full;
  wire tx_rd_ok = tx_rd_en && !tx_empty;
  wire rx_wr_ok = rx_wr_en && !rx_full;
  wire rx_rd_ok = rx_rd_en && !rx_empty;

  assign tx_free  = FULL - tx_cnt;
  assign rx_level = (rx_cnt >= CW'(LEVEL));

  always_ff @(posedge clk) begin
    if (tx_wr_ok) tx_mem[tx_wp] <= tx_wr_data;
    if (rx_wr_ok) rx_mem[rx_wp] <= rx_wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      tx_rd_data <= '0; tx_rd_valid <= 1'b0;
      tx_ovf <= 1'b0; tx_unf <= 1'b0;
    end else begin
      if (tx_wr_ok) tx_wp <= (tx_wp == LAST) ? '0 : tx_wp + 1'b1;
      if (tx_rd_ok) begin
        tx_rp      <= (tx_rp == LAST) ? '0 : tx_rp + 1'b1;
        tx_rd_data <= tx_mem[tx_rp];
      end
      tx_cnt      <= tx_cnt + CW'(tx_wr_ok) - CW'(tx_rd_ok);
      tx_rd_valid <= tx_rd_ok;
      tx_ovf      <= tx_wr_en && tx_full;
      tx_unf      <= tx_rd_en && tx_empty;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
      rx_rd_data <= '0; rx_rd_valid <= 1'b0; rx_rd_invalid <= 1'b0;
    end else begin
      if (rx_wr_ok) rx_wp <= (rx_wp == LAST) ? '0 : rx_wp + 1'b1;
      if (rx_rd_ok) begin
        rx_rp      <= (rx_rp == LAST) ? '0 : rx_rp + 1'b1;
        rx_rd_data <= rx_mem[rx_rp];
      end
      rx_cnt        <= rx_cnt + CW'(rx_wr_ok) - CW'(rx_rd_ok);
      rx_rd_valid   <= rx_rd_ok;
      rx_rd_invalid <= rx_rd_en && rx_empty;
    end
  end
endmodule

// File: rtl/hdlc_byte_fifo_pair_chk.sv
module hdlc_byte_fifo_pair_chk #(
  parameter int DEPTH = 256,
  parameter int LEVEL = 16,
  parameter int CW    = 9
) (
  input logic          clk,
  input logic          rst,
  input logic          tx_wr_en,
  input logic          tx_rd_en,
  input logic [CW-1:0] tx_free,
  input logic          tx_ovf,
  input logic          tx_unf,
  input logic          tx_rd_valid,
  input logic          rx_wr_en,
  input logic          rx_rd_en,
  input logic          rx_rd_valid,
  input logic          rx_rd_invalid,
  input logic          rx_level,
  input logic [CW-1:0] rx_cnt
);
  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  p_no_overflow_r1: assert property (@(posedge clk) disable iff (rst)
    (tx_wr_en && !tx_rd_en && tx_free == '0) |=> (tx_ovf && tx_free == '0));

  p_underflow_r2: assert property (@(posedge clk) disable iff (rst)
    (tx_rd_en && !tx_wr_en && tx_free == CW'(DEPTH)) |=> (tx_unf && !tx_rd_valid && tx_free == CW'(DEPTH)));

  p_empty_read_r3: assert property (@(posedge clk) disable iff (rst)
    (rx_rd_en && rx_cnt == '0) |=> (rx_rd_invalid && !rx_rd_valid));

  p_free_range_r4: assert property (@(posedge clk) disable iff (rst)
    tx_free <= CW'(DEPTH));

  p_level_rise_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_level) |-> $past(rx_wr_en));

  p_full_both_r8: assert property (@(posedge clk) disable iff (rst)
    (tx_wr_en && tx_rd_en && tx_free == '0) |=> (tx_ovf && tx_rd_valid && tx_free == CW'(1)));

  p_empty_both_r8: assert property (@(posedge clk) disable iff (rst)
    (rx_wr_en && rx_rd_en && rx_cnt == '0) |=> (rx_rd_invalid && rx_cnt == CW'(1)));

  always_ff @(posedge clk)
    if (rst_q && !rst)
      p_reset_state_r9: assert (tx_free == CW'(DEPTH) && !tx_ovf && !tx_unf && !tx_rd_valid
                                && !rx_rd_valid && !rx_rd_invalid && !rx_level);
endmodule

bind hdlc_byte_fifo_pair hdlc_byte_fifo_pair_chk #(.DEPTH(DEPTH), .LEVEL(LEVEL), .CW($clog2(DEPTH+1))) u_chk (
  .clk(clk), .rst(rst), .tx_wr_en(tx_wr_en), .tx_rd_en(tx_rd_en), .tx_free(tx_free),
  .tx_ovf(tx_ovf), .tx_unf(tx_unf), .tx_rd_valid(tx_rd_valid), .rx_wr_en(rx_wr_en),
  .rx_rd_en(rx_rd_en), .rx_rd_valid(rx_rd_valid), .rx_rd_invalid(rx_rd_invalid),
  .rx_level(rx_level), .rx_cnt(rx_cnt));

// File: tb/sim_hdlc_byte_fifo_pair.sv
`timescale 1ns/1ps
module sim_hdlc_byte_fifo_pair;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_wr_en = 0, tx_rd_en = 0, rx_wr_en = 0, rx_rd_en = 0;
  logic [7:0] tx_wr_data = 0, rx_wr_data = 0;
  logic [7:0] tx_rd_data, rx_rd_data;
  logic tx_rd_valid, tx_ovf, tx_unf, rx_rd_valid, rx_rd_invalid, rx_level;
  logic [8:0] tx_free;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  hdlc_byte_fifo_pair u0 (.*);

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tx_push(int b);
    tx_wr_en = 1; tx_wr_data = 8'(b); tick(); tx_wr_en = 0;
  endtask
  task automatic rx_push(int b);
    rx_wr_en = 1; rx_wr_data = 8'(b); tick(); rx_wr_en = 0;
  endtask
  task automatic tx_pop(string req, int exp);
    tx_rd_en = 1; tick(); tx_rd_en = 0;
    chk({req, " tx valid"}, tx_rd_valid, 1);
    chk({req, " tx data"}, tx_rd_data, exp);
  endtask
  task automatic rx_pop(string req, int exp);
    rx_rd_en = 1; tick(); rx_rd_en = 0;
    chk({req, " rx valid"}, rx_rd_valid, 1);
    chk({req, " rx data"}, rx_rd_data, exp);
  endtask
  task automatic do_reset();
    rst = 1; tick(); tick(); rst = 0;
  endtask

  task automatic t_reset();
    chk("R9 free", tx_free, 256);
    chk("R9 level", rx_level, 0);
    chk("R9 flags", {tx_ovf, tx_unf, rx_rd_invalid, tx_rd_valid, rx_rd_valid}, 0);
  endtask

  task automatic t_tx_order();
    tx_push(8'h11); tx_push(8'h22); tx_push(8'h33);
    chk("R4 free after 3", tx_free, 253);
    tx_pop("R6", 8'h11);
    chk("R4 free after pop", tx_free, 254);
    tx_pop("R6", 8'h22); tx_pop("R6", 8'h33);
    chk("R4 free empty", tx_free, 256);
  endtask

  task automatic t_tx_full();
    for (int i = 0; i < 256; i++) tx_push(i);
    chk("R4 free full", tx_free, 0);
    tx_push(8'hEE);
    chk("R1 ovf", tx_ovf, 1);
    chk("R1 free stays", tx_free, 0);
    tick();
    chk("R7 ovf one cycle", tx_ovf, 0);
    for (int i = 0; i < 256; i++) tx_pop("R1/R6", i);
    chk("R1 free after drain", tx_free, 256);
  endtask

  task automatic t_tx_under();
    tx_rd_en = 1; tick(); tx_rd_en = 0;
    chk("R2 unf", tx_unf, 1);
    chk("R2 valid low", tx_rd_valid, 0);
    chk("R2 free", tx_free, 256);
    tick();
    chk("R7 unf one cycle", tx_unf, 0);
    tx_push(8'h77); tx_pop("R2 no pointer move", 8'h77);
  endtask

  task automatic t_rx_level();
    for (int i = 0; i < 15; i++) rx_push(i + 100);
    chk("R5 level at 15", rx_level, 0);
    rx_push(115);
    chk("R5 level at 16", rx_level, 1);
    rx_pop("R5", 100);
    chk("R5 level back to 15", rx_level, 0);
    for (int i = 1; i < 16; i++) rx_pop("R6 rx", i + 100);
  endtask

  task automatic t_rx_empty();
    rx_rd_en = 1; tick(); rx_rd_en = 0;
    chk("R3 invalid", rx_rd_invalid, 1);
    chk("R3 valid low", rx_rd_valid, 0);
    tick();
    chk("R7 invalid one cycle", rx_rd_invalid, 0);
    rx_push(8'h5A);
    rx_pop("R3 pointer kept", 8'h5A);
  endtask

  task automatic t_simul();
    for (int i = 0; i < 256; i++) tx_push(255 - i);
    tx_wr_en = 1; tx_wr_data = 8'hAB; tx_rd_en = 1; tick();
    tx_wr_en = 0; tx_rd_en = 0;
    chk("R8 ovf with read", tx_ovf, 1);
    chk("R8 read accepted", tx_rd_valid, 1);
    chk("R8 read data", tx_rd_data, 255);
    chk("R8 free", tx_free, 1);
    for (int i = 1; i < 256; i++) tx_pop("R8 drain", 255 - i);
    chk("R8 write dropped", tx_free, 256);
    rx_wr_en = 1; rx_wr_data = 8'hC3; rx_rd_en = 1; tick();
    rx_wr_en = 0; rx_rd_en = 0;
    chk("R8 rx invalid", rx_rd_invalid, 1);
    chk("R8 rx valid low", rx_rd_valid, 0);
    rx_pop("R8 rx write kept", 8'hC3);
  endtask

  task automatic t_rx_full();
    for (int i = 0; i < 256; i++) rx_push(i ^ 8'h5C);
    rx_push(8'hFF ^ 8'h5C ^ 8'h01);
    for (int i = 0; i < 256; i++) rx_pop("R10", i ^ 8'h5C);
    rx_rd_en = 1; tick(); rx_rd_en = 0;
    chk("R10 extra dropped", rx_rd_invalid, 1);
  endtask

  task automatic t_mid_reset();
    tx_push(1); tx_push(2); rx_push(3);
    for (int i = 0; i < 16; i++) rx_push(i);
    do_reset();
    chk("R9 free after reset", tx_free, 256);
    chk("R9 level after reset", rx_level, 0);
    rx_rd_en = 1; tick(); rx_rd_en = 0;
    chk("R9 rx emptied", rx_rd_invalid, 1);
  endtask

  initial begin
    tick(); tick(); rst = 0;
    t_reset();
    t_tx_order();
    t_tx_full();
    t_tx_under();
    t_rx_level();
    t_rx_empty();
    t_simul();
    t_rx_full();
    t_mid_reset();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule